// File: doc/BRIEF.md
# Two-page three-port scratchpad with per-page fixed-priority arbitration

This block is an 8 KB on-chip scratchpad built as two independent 4 KB pages. Three requesters share it: a system-bus master (port 0), an operand load/store path (port 1) and an instruction-fetch path (port 2). Every page has its own arbiter, so two requesters that address different pages are both served in the same cycle. When requesters collide on one page, the system-bus master is served first, then the operand path, then the fetch path. The losers keep their request up until they are served.

Each port uses a valid/ready request handshake. A request carries a 32-bit address, a write flag, write data and four byte-enable lanes. One cycle after a request is accepted, the port's response strobe pulses. For a read, the stored word comes back in that same cycle. The block decodes one fixed 8 KB window starting at 0xE520_0000. The same decode serves virtual and physical addresses, because no translation happens here. A request outside the window is accepted at once, touches no storage, and comes back flagged as an error.

Top module: `spm_tri_port`

## Requirements
- R1: An address is inside the window when its bits 31:13 equal those of 0xE520_0000. Inside the window, address bit 12 picks the page (0 or 1) and bits 11:2 pick a 32-bit word within that page.
- R2: A request outside the window has ready high in the same cycle, whatever the other ports do. The cycle after, the port gives rsp_valid=1, rsp_err=1 and rsp_rdata=0. Storage is left unchanged.
- R3: At most one port is accepted per page per cycle.
- R4: On a page, a valid port is accepted exactly when no lower-numbered port targets the same page in that cycle. Port 0 (system bus) beats port 1 (operand), and port 1 beats port 2 (fetch).
- R5: Ports that target different pages are all accepted in the same cycle.
- R6: A port that loses arbitration sees ready=0. Once the higher-priority requests on its page go away, it is accepted in the first such cycle.
- R7: On a write, byte lane b (bits 8b+7:8b) of the addressed word changes only when be[b]=1. Lanes with be[b]=0 keep their old value.
- R8: Every accepted request, read or write, gives exactly one rsp_valid pulse on its own port one cycle after acceptance. For an in-window read, rsp_rdata then carries the addressed word with rsp_err=0. A write is visible to a read accepted in the next cycle.
- R9: After reset, rsp_valid and rsp_err are 0 on all ports. With no valid requests, ready is 0 on all ports.
- R10: The same word offset in page 0 and in page 1 refers to separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response state |
| req_valid | input | 3 | Request valid per port (0 system, 1 operand, 2 fetch) |
| req_ready | output | 3 | Request accepted this cycle, per port |
| req_addr | input | 3x32 | Byte address per port |
| req_write | input | 3 | 1 = write, 0 = read, per port |
| req_wdata | input | 3x32 | Write data per port |
| req_be | input | 3x4 | Byte-lane enables per port |
| rsp_valid | output | 3 | Response strobe, one cycle after acceptance |
| rsp_err | output | 3 | Response is for an out-of-window request |
| rsp_rdata | output | 3x32 | Read data, zero unless an in-window read response |

## Verification
A wrong grant vector shows at req_ready in the same cycle as the conflicting requests. A priority inversion or a lost parallel grant is therefore visible without delay. A wrong page or word select, or a bad byte-lane mask, stays hidden in storage until that word is read back. It then appears as a data mismatch on rsp_rdata one cycle after the read is accepted. A response register that is stuck or steered to the wrong port shows as a missing, extra or misplaced rsp_valid pulse one cycle after acceptance.

// File: rtl/spm_pkg.sv
package spm_pkg;

  localparam int NPORT = 3;
  localparam int NPAGE = 2;

  typedef enum logic [1:0] {
    PORT_SYS   = 2'd0,
    PORT_OPND  = 2'd1,
    PORT_FETCH = 2'd2
  } port_id_e;

  // Window hit: all address bits above the window size match the base.
  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input int unsigned win_lg2);
    return (addr >> win_lg2) == (base >> win_lg2);
  endfunction

  // Fixed-priority pick: lowest index wins.
  function automatic logic [NPORT-1:0] pick_fixed(input logic [NPORT-1:0] req);
    logic [NPORT-1:0] g;
    logic             taken;
    g     = '0;
    taken = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && !taken) begin
        g[i]  = 1'b1;
        taken = 1'b1;
      end
    end
    return g;
  endfunction

  // Mask of ports with a lower index than i (higher priority).
  function automatic logic [NPORT-1:0] above_mask(input int unsigned i);
    logic [NPORT-1:0] m;
    m = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (k < int'(i)) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/spm_addr_decode.sv
module spm_addr_decode #(
  parameter logic [31:0] BASE_ADDR = 32'hE520_0000,
  parameter int unsigned PAGE_LG2  = 12,
  localparam int unsigned WORD_AW  = PAGE_LG2 - 2,
  localparam int unsigned WIN_LG2  = PAGE_LG2 + 1
) (
  input  logic [31:0]        addr,
  output logic               hit,
  output logic               page,
  output logic [WORD_AW-1:0] word
);

  assign hit  = spm_pkg::win_hit(addr, BASE_ADDR, WIN_LG2);
  assign page = addr[PAGE_LG2];
  assign word = addr[PAGE_LG2-1:2];

endmodule

// File: rtl/spm_page_arb.sv
module spm_page_arb #(
  parameter int unsigned NP = spm_pkg::NPORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  output logic [NP-1:0] gnt,
  output logic          busy
);

  assign gnt  = spm_pkg::pick_fixed(req);
  assign busy = |gnt;

  // R3: a page serves at most one port per cycle
  a_r3_gnt_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4: the system-bus port is never stalled on a page it requests
  a_r4_sys_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);

  // R6: a requested page never sits idle
  a_r6_no_idle_page: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> busy);

  // R3: grants only go to requesters
  a_r3_gnt_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/spm_page_ram.sv
module spm_page_ram #(
  parameter int unsigned WORD_AW = 10,
  parameter int unsigned NBYTE   = 4,
  localparam int unsigned DW     = 8 * NBYTE,
  localparam int unsigned DEPTH  = 1 << WORD_AW
) (
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic [NBYTE-1:0]   be,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < int'(NBYTE); b++) begin
          if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/spm_resp_reg.sv
module spm_resp_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic err_in,
  input  logic rd_in,
  input  logic page_in,
  output logic rsp_valid,
  output logic rsp_err,
  output logic rd_q,
  output logic page_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_q      <= 1'b0;
      page_q    <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept & err_in;
      rd_q      <= accept & rd_in;
      page_q    <= page_in;
    end
  end

  // R8: each acceptance yields a response pulse in the next cycle
  a_r8_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R8: no response without a preceding acceptance
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R2: an out-of-window acceptance returns an error flag
  a_r2_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && err_in) |=> rsp_err);

endmodule

// File: rtl/spm_tri_port.sv
module spm_tri_port #(
  parameter logic [31:0] BASE_ADDR  = 32'hE520_0000,
  parameter int unsigned PAGE_BYTES = 4096,
  localparam int unsigned NP        = spm_pkg::NPORT,
  localparam int unsigned NG        = spm_pkg::NPAGE,
  localparam int unsigned PAGE_LG2  = $clog2(PAGE_BYTES),
  localparam int unsigned WORD_AW   = PAGE_LG2 - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP-1:0]       req_valid,
  output logic [NP-1:0]       req_ready,
  input  logic [NP-1:0][31:0] req_addr,
  input  logic [NP-1:0]       req_write,
  input  logic [NP-1:0][31:0] req_wdata,
  input  logic [NP-1:0][3:0]  req_be,
  output logic [NP-1:0]       rsp_valid,
  output logic [NP-1:0]       rsp_err,
  output logic [NP-1:0][31:0] rsp_rdata
);

  // Per-port decode results
  logic [NP-1:0]       port_hit;
  logic [NP-1:0]       port_page;
  logic [WORD_AW-1:0]  port_word [NP];
  logic [NP-1:0]       port_accept;
  logic [NP-1:0]       port_rd_q;
  logic [NP-1:0]       port_page_q;

  // Per-page arbitration and storage signals
  logic [NP-1:0]       pg_req  [NG];
  logic [NP-1:0]       pg_gnt  [NG];
  logic [NG-1:0]       pg_busy;
  logic [NG-1:0]       pg_we;
  logic [3:0]          pg_be   [NG];
  logic [WORD_AW-1:0]  pg_word [NG];
  logic [31:0]         pg_wdata[NG];
  logic [31:0]         pg_rdata[NG];

  for (genvar p = 0; p < NP; p++) begin : g_port
    spm_addr_decode #(
      .BASE_ADDR (BASE_ADDR),
      .PAGE_LG2  (PAGE_LG2)
    ) u_dec (
      .addr (req_addr[p]),
      .hit  (port_hit[p]),
      .page (port_page[p]),
      .word (port_word[p])
    );
  end

  // Route each in-window request to the arbiter of its page
  always_comb begin
    for (int g = 0; g < int'(NG); g++) begin
      for (int p = 0; p < int'(NP); p++) begin
        pg_req[g][p] = req_valid[p] && port_hit[p] && (int'(port_page[p]) == g);
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_page
    spm_page_arb #(.NP(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (pg_req[g]),
      .gnt   (pg_gnt[g]),
      .busy  (pg_busy[g])
    );

    // Steer the winning port's request onto this page
    always_comb begin
      pg_we[g]    = 1'b0;
      pg_be[g]    = '0;
      pg_word[g]  = '0;
      pg_wdata[g] = '0;
      for (int p = 0; p < int'(NP); p++) begin
        if (pg_gnt[g][p]) begin
          pg_we[g]    = req_write[p];
          pg_be[g]    = req_be[p];
          pg_word[g]  = port_word[p];
          pg_wdata[g] = req_wdata[p];
        end
      end
    end

    spm_page_ram #(.WORD_AW(WORD_AW), .NBYTE(4)) u_ram (
      .clk   (clk),
      .en    (pg_busy[g]),
      .we    (pg_we[g]),
      .be    (pg_be[g]),
      .addr  (pg_word[g]),
      .wdata (pg_wdata[g]),
      .rdata (pg_rdata[g])
    );
  end

  // Accept: out-of-window requests at once, in-window ones on a page grant
  always_comb begin
    for (int p = 0; p < int'(NP); p++) begin
      port_accept[p] = req_valid[p] &&
                       (!port_hit[p] || pg_gnt[port_page[p]][p]);
    end
  end
  assign req_ready = port_accept;

  for (genvar p = 0; p < NP; p++) begin : g_rsp
    spm_resp_reg u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (port_accept[p]),
      .err_in    (!port_hit[p]),
      .rd_in     (!req_write[p]),
      .page_in   (port_page[p]),
      .rsp_valid (rsp_valid[p]),
      .rsp_err   (rsp_err[p]),
      .rd_q      (port_rd_q[p]),
      .page_q    (port_page_q[p])
    );

    assign rsp_rdata[p] = (rsp_valid[p] && port_rd_q[p] && !rsp_err[p])
                          ? pg_rdata[port_page_q[p]] : 32'h0;

    // R2: out-of-window requests are never stalled
    a_r2_oow_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !port_hit[p]) |-> req_ready[p]);

    // R6: a stalled in-window port always has a higher-priority rival on its page
    a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && port_hit[p] && !req_ready[p]) |->
      ((pg_req[port_page[p]] & spm_pkg::above_mask(p)) != '0));

    // R9: no ready without valid
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[p] |-> req_valid[p]);
  end

  for (genvar g = 0; g < NG; g++) begin : g_pgchk
    // R3: counted at the ports, at most one in-window acceptance per page
    a_r3_one_per_page: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_ready & port_hit & (g == 0 ? ~port_page : port_page)) <= 1);
  end

  // R5: the two top-priority ports on different pages both proceed
  a_r5_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_valid[1] && port_hit[0] && port_hit[1] &&
     (port_page[0] != port_page[1])) |-> (req_ready[0] && req_ready[1]));

endmodule

// File: tb/spm_tri_port_tb.sv
module spm_tri_port_tb;

  localparam logic [31:0] BASE = 32'hE520_0000;
  localparam int WORDS = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        req_valid = '0;
  logic [2:0]        req_ready;
  logic [2:0][31:0]  req_addr = '0;
  logic [2:0]        req_write = '0;
  logic [2:0][31:0]  req_wdata = '0;
  logic [2:0][3:0]   req_be = '0;
  logic [2:0]        rsp_valid;
  logic [2:0]        rsp_err;
  logic [2:0][31:0]  rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model [2][WORDS];

  always #2 clk = ~clk;

  spm_tri_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  function automatic logic [31:0] pat(input int pg, input int w);
    return 32'hA500_0000 ^ (pg << 20) ^ (w * 32'h0001_0003);
  endfunction

  function automatic logic [31:0] waddr(input int pg, input int w);
    return BASE + (pg * 4096) + (w * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive current request set, sample ready, then sample the response
  task automatic cyc(output logic [2:0] rdy, output logic [2:0] rv,
                     output logic [2:0] re, output logic [2:0][31:0] rd);
    #1 rdy = req_ready;
    @(negedge clk);
    rv = rsp_valid;
    re = rsp_err;
    rd = rsp_rdata;
    req_valid = '0;
  endtask

  task automatic single(input int p, input logic [31:0] a, input logic w,
                        input logic [31:0] d, input logic [3:0] b,
                        output logic rdy, output logic rv, output logic re,
                        output logic [31:0] rd);
    logic [2:0] r3, v3, e3;
    logic [2:0][31:0] d3;
    req_valid = '0;
    req_valid[p] = 1'b1;
    req_addr[p]  = a;
    req_write[p] = w;
    req_wdata[p] = d;
    req_be[p]    = b;
    cyc(r3, v3, e3, d3);
    rdy = r3[p];
    rv  = v3[p];
    re  = e3[p];
    rd  = d3[p];
  endtask

  initial begin
    logic rdy, rv, re;
    logic [31:0] rd;
    logic [2:0] r3, v3, e3, exp_r;
    logic [2:0][31:0] d3;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rsp_valid in reset", {29'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rsp_valid after reset", {29'd0, rsp_valid}, 32'd0);
    chk("R9 rsp_err after reset", {29'd0, rsp_err}, 32'd0);
    #1 chk("R9 ready idle", {29'd0, req_ready}, 32'd0);
    @(negedge clk);

    // R1/R10: fill both pages through rotating ports
    for (int pg = 0; pg < 2; pg++) begin
      for (int w = 0; w < WORDS; w++) begin
        single((pg * WORDS + w) % 3, waddr(pg, w), 1'b1, pat(pg, w), 4'hF, rdy, rv, re, rd);
        model[pg][w] = pat(pg, w);
        if (!rdy || !rv || re) chk("R1 R8 write accepted", {rdy, rv, re}, 3'b110);
        else checks++;
      end
    end
    // R8/R10: read everything back through a different port
    for (int pg = 0; pg < 2; pg++) begin
      for (int w = 0; w < WORDS; w++) begin
        single((pg * WORDS + w + 1) % 3, waddr(pg, w), 1'b0, 32'h0, 4'h0, rdy, rv, re, rd);
        chk("R10 R8 readback", rd, model[pg][w]);
      end
    end

    // R7: all byte-enable patterns on one word
    for (int b = 0; b < 16; b++) begin
      logic [31:0] nv;
      nv = 32'h1122_3344 + b * 32'h0101_0101;
      single(1, waddr(1, 5), 1'b1, nv, b[3:0], rdy, rv, re, rd);
      for (int k = 0; k < 4; k++)
        if (b[k]) model[1][5][8*k +: 8] = nv[8*k +: 8];
      single(2, waddr(1, 5), 1'b0, 32'h0, 4'h0, rdy, rv, re, rd);
      chk("R7 byte lanes", rd, model[1][5]);
    end

    // R3/R4/R5/R6: every valid mask with every page assignment
    for (int m = 1; m < 8; m++) begin
      for (int ps = 0; ps < 8; ps++) begin
        for (int p = 0; p < 3; p++) begin
          req_valid[p] = m[p];
          req_addr[p]  = waddr(ps[p], p * 7 + m * 3 + ps);
          req_write[p] = 1'b0;
        end
        for (int p = 0; p < 3; p++) begin
          exp_r[p] = m[p];
          for (int q = 0; q < p; q++)
            if (m[q] && ps[q] == ps[p]) exp_r[p] = 1'b0;
        end
        cyc(r3, v3, e3, d3);
        chk($sformatf("R4 R5 ready m=%0d ps=%0d", m, ps), {29'd0, r3}, {29'd0, exp_r});
        chk("R3 R8 response set", {29'd0, v3}, {29'd0, exp_r});
        for (int p = 0; p < 3; p++)
          if (exp_r[p]) chk("R8 priority read data", d3[p], model[ps[p]][p * 7 + m * 3 + ps]);
      end
    end

    // R6: stalled fetch port proceeds once the system port leaves
    req_valid = 3'b101;
    req_addr[0] = waddr(0, 9);   req_write[0] = 1'b0;
    req_addr[2] = waddr(0, 10);  req_write[2] = 1'b0;
    #1 chk("R6 fetch stalled", {29'd0, req_ready}, 32'd5 & 32'd1);
    @(negedge clk);
    req_valid = 3'b100;
    #1 chk("R6 fetch granted after", {29'd0, req_ready}, 32'd4);
    @(negedge clk);
    chk("R6 fetch data", rsp_rdata[2], model[0][10]);
    chk("R6 response on fetch only", {29'd0, rsp_valid}, 32'd4);
    req_valid = '0;
    @(negedge clk);

    // R2: out-of-window requests, including an alias of word 0
    single(0, 32'hE520_2000, 1'b1, 32'hDEAD_BEEF, 4'hF, rdy, rv, re, rd);
    chk("R2 oow ready", {29'd0, rdy, rv, re}, 32'd7);
    single(1, 32'hE51F_FFFC, 1'b1, 32'hDEAD_BEEF, 4'hF, rdy, rv, re, rd);
    chk("R2 oow below ready", {29'd0, rdy, rv, re}, 32'd7);
    single(2, 32'h0000_0000, 1'b0, 32'h0, 4'h0, rdy, rv, re, rd);
    chk("R2 oow read data zero", rd, 32'h0);
    chk("R2 oow read err", {31'd0, re}, 32'd1);
    single(0, waddr(0, 0), 1'b0, 32'h0, 4'h0, rdy, rv, re, rd);
    chk("R2 storage untouched p0", rd, model[0][0]);
    single(0, waddr(1, 1023), 1'b0, 32'h0, 4'h0, rdy, rv, re, rd);
    chk("R2 storage untouched p1", rd, model[1][1023]);
    // R2: out-of-window beside a conflict on page 0
    req_valid = 3'b111;
    req_addr[0] = 32'hE520_4000; req_write[0] = 1'b0;
    req_addr[1] = waddr(0, 3);   req_write[1] = 1'b0;
    req_addr[2] = waddr(0, 4);   req_write[2] = 1'b0;
    cyc(r3, v3, e3, d3);
    chk("R2 oow does not block", {29'd0, r3}, 32'd3);
    chk("R2 oow err only on port0", {29'd0, e3}, 32'd1);
    chk("R8 operand data beside oow", d3[1], model[0][3]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule